// File: doc/BRIEF.md
# Overlap-Safe Nibble Block Mover

This block copies a run of 4-bit nibbles from one place to another in a memory of 2^20 nibbles. The caller gives a source pointer, a destination pointer, a 20-bit nibble count and a direction bit, then pulses `start`. The block works in chunks of up to 16 nibbles. For each chunk it reads every nibble into a small local buffer before it writes any of them back. The memory port carries one access per cycle and returns read data some cycles later, marked by a valid strobe.

With `dir_up` low (downward move), the copy begins at the lowest addresses and both pointers advance after each chunk. With `dir_up` high (upward move), both pointers first step back by the chunk size, and that chunk is then copied at the new addresses. A region can therefore be shifted toward higher addresses over itself without corrupting it. All pointer arithmetic wraps at 2^20. At the end the updated pointers sit on `src_out`/`dst_out`, a one-cycle `done` pulse is raised, and the 4-bit `ptr_p` field and the `carry_out` flag are both cleared.

Top module: `nbm_block_mover`

## Requirements
- R1: A start accepted with a count of zero makes no memory access and raises `done` in the cycle after the start. `src_out`/`dst_out` then equal the given pointers, and `busy` stays low.
- R2: Every nibble of the count is read exactly once and written exactly once. Chunks hold at most 16 nibbles, and all reads of a chunk come before any write of that chunk. A read and a write never share a cycle, and the memory port is used only while `busy` is high.
- R3: With `dir_up`=0, chunk k is read at the source pointer and written at the destination pointer, and both pointers then advance by the chunk size. At the end, `src_out` = src+count and `dst_out` = dst+count.
- R4: With `dir_up`=1, both pointers are first lowered by the chunk size, and the chunk is then read and written at the lowered pointers. At the end, `src_out` = src−count and `dst_out` = dst−count.
- R5: Every address and pointer wraps modulo 2^20, so a region may straddle 0xFFFFF/0x00000.
- R6: Source reads are side-effect-free peeks. `mem_csum` is never asserted.
- R7: At completion `done` is high for exactly one cycle, `busy` falls in that same cycle, and `ptr_p`=0 and `carry_out`=0.
- R8: `start` is ignored while `busy` is high. The running copy and its final pointers are unchanged by it.
- R9: An accepted non-zero start loads `ptr_p` from `p_in` and `carry_out` from `carry_in`, and raises `busy` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a copy (sampled only when idle) |
| dir_up | input | 1 | 0: copy from low addresses upward, 1: copy from the end downward |
| src_in | input | 20 | Source nibble pointer |
| dst_in | input | 20 | Destination nibble pointer |
| len_in | input | 20 | Nibble count |
| p_in | input | 4 | Value loaded into `ptr_p` at start |
| carry_in | input | 1 | Value loaded into `carry_out` at start |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle completion pulse |
| src_out | output | 20 | Source pointer register |
| dst_out | output | 20 | Destination pointer register |
| ptr_p | output | 4 | 4-bit pointer field, cleared at completion |
| carry_out | output | 1 | Carry flag, cleared at completion |
| mem_addr | output | 20 | Memory nibble address |
| mem_rd | output | 1 | Read request |
| mem_wr | output | 1 | Write request |
| mem_wdata | output | 4 | Write data |
| mem_csum | output | 1 | Checksum-update strobe (held low) |
| mem_rdata | input | 4 | Read data |
| mem_rvalid | input | 1 | Read data valid |

## Verification
Two things can happen in the same cycle. Read data can return and be captured into the chunk buffer while later reads of that chunk are still being issued. A new `start` can also arrive while `busy` is high. The bench provokes the first with a memory model that has a two-cycle read latency, so capture and issue overlap on every chunk longer than two nibbles. It judges the result by comparing the whole memory with a chunk-by-chunk reference model, using overlapping and wrapping regions. It provokes the second by pulsing `start` with different pointers and count in mid-copy, then checks that the final pointers and memory match the original request.

// File: rtl/nbm_pkg.sv
package nbm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_READ,
    ST_WRITE,
    ST_ADV
  } nbm_state_t;
endpackage

// File: rtl/nbm_chunk_sizer.sv
module nbm_chunk_sizer #(
  parameter int AW    = 20,
  parameter int CHUNK = 16,
  parameter int CW    = 5
) (
  input  logic [AW-1:0] rem,
  output logic [CW-1:0] size
);
  always_comb begin
    if (rem >= AW'(CHUNK)) size = CW'(CHUNK);
    else                   size = rem[CW-1:0];
  end
endmodule

// File: rtl/nbm_wrap_add.sv
module nbm_wrap_add #(
  parameter int AW  = 20,
  parameter int OW  = 5,
  parameter bit SUB = 1'b0
) (
  input  logic [AW-1:0] base,
  input  logic [OW-1:0] off,
  output logic [AW-1:0] res
);
  logic [AW-1:0] off_ext;
  assign off_ext = {{(AW-OW){1'b0}}, off};

  generate
    if (SUB) begin : g_sub
      assign res = base - off_ext;
    end else begin : g_add
      assign res = base + off_ext;
    end
  endgenerate
endmodule

// File: rtl/nbm_chunk_buf.sv
module nbm_chunk_buf #(
  parameter int DW    = 4,
  parameter int DEPTH = 16,
  parameter int IW    = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    rdata <= store[raddr];
  end
endmodule

// File: rtl/nbm_block_mover.sv
module nbm_block_mover #(
  parameter int AW    = 20,
  parameter int DW    = 4,
  parameter int PW    = 4,
  parameter int CHUNK = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          dir_up,
  input  logic [AW-1:0] src_in,
  input  logic [AW-1:0] dst_in,
  input  logic [AW-1:0] len_in,
  input  logic [PW-1:0] p_in,
  input  logic          carry_in,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] src_out,
  output logic [AW-1:0] dst_out,
  output logic [PW-1:0] ptr_p,
  output logic          carry_out,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_csum,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_rvalid
);
  import nbm_pkg::*;

  localparam int IW = $clog2(CHUNK);
  localparam int CW = IW + 1;

  nbm_state_t    state;
  logic          dir_q;
  logic [AW-1:0] rem_q;
  logic [CW-1:0] n_q;
  logic [CW-1:0] rd_cnt;
  logic [CW-1:0] cap_cnt;
  logic [CW-1:0] wr_idx;
  logic          wv;
  logic [IW-1:0] wi;

  logic [CW-1:0] chunk;
  logic [AW-1:0] src_rd_addr, dst_wr_addr;
  logic [AW-1:0] src_dec, dst_dec, src_inc, dst_inc;
  logic [DW-1:0] buf_q;
  logic          buf_we;

  // Peeks only: the checksum strobe stays low on every access.
  assign mem_csum = 1'b0;

  nbm_chunk_sizer #(.AW(AW), .CHUNK(CHUNK), .CW(CW)) i_sizer (
    .rem(rem_q), .size(chunk));

  nbm_wrap_add #(.AW(AW), .OW(CW), .SUB(1'b0)) i_rd_addr (
    .base(src_out), .off(rd_cnt), .res(src_rd_addr));
  nbm_wrap_add #(.AW(AW), .OW(CW), .SUB(1'b0)) i_wr_addr (
    .base(dst_out), .off({1'b0, wi}), .res(dst_wr_addr));
  nbm_wrap_add #(.AW(AW), .OW(CW), .SUB(1'b1)) i_src_dec (
    .base(src_out), .off(chunk), .res(src_dec));
  nbm_wrap_add #(.AW(AW), .OW(CW), .SUB(1'b1)) i_dst_dec (
    .base(dst_out), .off(chunk), .res(dst_dec));
  nbm_wrap_add #(.AW(AW), .OW(CW), .SUB(1'b0)) i_src_inc (
    .base(src_out), .off(n_q), .res(src_inc));
  nbm_wrap_add #(.AW(AW), .OW(CW), .SUB(1'b0)) i_dst_inc (
    .base(dst_out), .off(n_q), .res(dst_inc));

  assign buf_we = (state == ST_READ) && mem_rvalid;

  nbm_chunk_buf #(.DW(DW), .DEPTH(CHUNK), .IW(IW)) i_buf (
    .clk   (clk),
    .we    (buf_we),
    .waddr (cap_cnt[IW-1:0]),
    .wdata (mem_rdata),
    .raddr (wr_idx[IW-1:0]),
    .rdata (buf_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      dir_q     <= 1'b0;
      rem_q     <= '0;
      n_q       <= '0;
      rd_cnt    <= '0;
      cap_cnt   <= '0;
      wr_idx    <= '0;
      wv        <= 1'b0;
      wi        <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      src_out   <= '0;
      dst_out   <= '0;
      ptr_p     <= '0;
      carry_out <= 1'b0;
      mem_addr  <= '0;
      mem_rd    <= 1'b0;
      mem_wr    <= 1'b0;
      mem_wdata <= '0;
    end else begin
      done   <= 1'b0;
      mem_rd <= 1'b0;
      mem_wr <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            src_out <= src_in;
            dst_out <= dst_in;
            dir_q   <= dir_up;
            if (len_in == '0) begin
              done      <= 1'b1;
              ptr_p     <= '0;
              carry_out <= 1'b0;
            end else begin
              busy      <= 1'b1;
              rem_q     <= len_in;
              ptr_p     <= p_in;
              carry_out <= carry_in;
              state     <= ST_SETUP;
            end
          end
        end
        ST_SETUP: begin
          n_q     <= chunk;
          rd_cnt  <= '0;
          cap_cnt <= '0;
          wr_idx  <= '0;
          wv      <= 1'b0;
          if (dir_q) begin
            src_out <= src_dec;
            dst_out <= dst_dec;
          end
          state <= ST_READ;
        end
        ST_READ: begin
          if (rd_cnt != n_q) begin
            mem_rd   <= 1'b1;
            mem_addr <= src_rd_addr;
            rd_cnt   <= rd_cnt + CW'(1);
          end
          if (mem_rvalid) begin
            cap_cnt <= cap_cnt + CW'(1);
            if (cap_cnt == n_q - CW'(1)) state <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          if (wr_idx != n_q) begin
            wr_idx <= wr_idx + CW'(1);
            wv     <= 1'b1;
            wi     <= wr_idx[IW-1:0];
          end else begin
            wv <= 1'b0;
          end
          if (wv) begin
            mem_wr    <= 1'b1;
            mem_addr  <= dst_wr_addr;
            mem_wdata <= buf_q;
          end
          if (wr_idx == n_q && !wv) state <= ST_ADV;
        end
        ST_ADV: begin
          if (!dir_q) begin
            src_out <= src_inc;
            dst_out <= dst_inc;
          end
          rem_q <= rem_q - AW'(n_q);
          if (rem_q == AW'(n_q)) begin
            done      <= 1'b1;
            busy      <= 1'b0;
            ptr_p     <= '0;
            carry_out <= 1'b0;
            state     <= ST_IDLE;
          end else begin
            state <= ST_SETUP;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nbm_checker.sv
module nbm_checker #(
  parameter int AW = 20,
  parameter int PW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic [AW-1:0] len_in,
  input logic          busy,
  input logic          done,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic [PW-1:0] ptr_p,
  input logic          carry_out
);
  assert_zero_len_R1: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && len_in == '0) |=> (done && !busy));

  assert_port_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  assert_access_busy_R2: assert property (@(posedge clk) disable iff (rst)
    (mem_rd || mem_wr) |-> busy);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_clears_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> (ptr_p == '0 && !carry_out && !busy));

  assert_busy_end_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> (busy || done));
endmodule

bind nbm_block_mover nbm_checker #(.AW(AW), .PW(PW)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .len_in    (len_in),
  .busy      (busy),
  .done      (done),
  .mem_rd    (mem_rd),
  .mem_wr    (mem_wr),
  .ptr_p     (ptr_p),
  .carry_out (carry_out));

// File: tb/test_nbm_block_mover.sv
`timescale 1ns/1ps
module test_nbm_block_mover;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        dir_up = 1'b0;
  logic [19:0] src_in = '0, dst_in = '0, len_in = '0;
  logic [3:0]  p_in = '0;
  logic        carry_in = 1'b0;
  logic        busy, done, carry_out, mem_rd, mem_wr, mem_csum;
  logic [19:0] src_out, dst_out, mem_addr;
  logic [3:0]  ptr_p, mem_wdata;
  logic [3:0]  mem_rdata = '0;
  logic        mem_rvalid = 1'b0;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  nbm_block_mover i_nbm_block_mover (
    .clk(clk), .rst(rst), .start(start), .dir_up(dir_up),
    .src_in(src_in), .dst_in(dst_in), .len_in(len_in),
    .p_in(p_in), .carry_in(carry_in),
    .busy(busy), .done(done), .src_out(src_out), .dst_out(dst_out),
    .ptr_p(ptr_p), .carry_out(carry_out),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_csum(mem_csum),
    .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid));

  // memory contents: sparse, default derived from the address
  logic [3:0] dut_m [int];
  logic [3:0] ref_m [int];

  function automatic logic [3:0] init_nib(int a);
    int t = a * 7 + (a >>> 5) + (a >>> 11);
    return t[3:0];
  endfunction
  function automatic logic [3:0] peek_dut(int a);
    return dut_m.exists(a) ? dut_m[a] : init_nib(a);
  endfunction
  function automatic logic [3:0] peek_ref(int a);
    return ref_m.exists(a) ? ref_m[a] : init_nib(a);
  endfunction

  // memory model: two-cycle read latency
  int          rd_seen = 0, wr_seen = 0, csum_seen = 0;
  logic        p1_v = 1'b0;
  logic [19:0] p1_a = '0;
  always @(posedge clk) begin
    mem_rvalid <= p1_v;
    mem_rdata  <= peek_dut(int'(p1_a));
    p1_v <= mem_rd;
    p1_a <= mem_addr;
    if (mem_rd) rd_seen++;
    if (mem_csum) csum_seen++;
    if (mem_wr) begin
      dut_m[int'(mem_addr)] = mem_wdata;
      wr_seen++;
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // chunked reference copy, built from the requirements
  task automatic model(input logic d, input logic [19:0] s, input logic [19:0] t, input logic [19:0] len);
    int rem = int'(len);
    logic [19:0] ps = s, pt = t;
    logic [3:0] tmp [16];
    while (rem > 0) begin
      int n = (rem > 16) ? 16 : rem;
      if (d) begin ps = ps - 20'(n); pt = pt - 20'(n); end
      for (int i = 0; i < n; i++) tmp[i] = peek_ref(int'(20'(ps + 20'(i))));
      for (int i = 0; i < n; i++) ref_m[int'(20'(pt + 20'(i)))] = tmp[i];
      if (!d) begin ps = ps + 20'(n); pt = pt + 20'(n); end
      rem -= n;
    end
  endtask

  task automatic run_copy(input logic d, input logic [19:0] s, input logic [19:0] t,
                          input logic [19:0] len, input logic [3:0] p, input logic c,
                          input bit poke, input string tag);
    logic [19:0] es, et;
    int errs = 0;
    int wd = 0;
    bit got;
    es = d ? s - len : s + len;
    et = d ? t - len : t + len;
    model(d, s, t, len);
    rd_seen = 0; wr_seen = 0; csum_seen = 0;
    @(negedge clk);
    dir_up = d; src_in = s; dst_in = t; len_in = len; p_in = p; carry_in = c;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    got = done;
    if (len == 0) begin
      chk(done === 1'b1 && busy === 1'b0, "R1 zero-count done", {62'd0, busy, done}, 64'h1);
    end else begin
      chk(busy === 1'b1 && ptr_p === p && carry_out === c, "R9 start loads",
          {59'd0, busy, ptr_p, carry_out}, {59'd0, 1'b1, p, c});
    end
    if (poke) begin
      // R8: second start while busy with different arguments
      @(negedge clk);
      dir_up = ~d; src_in = 20'hAAAAA; dst_in = 20'h55555; len_in = 20'd5;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!got && wd < 4000) begin
      @(negedge clk);
      wd++;
      if (done) got = 1'b1;
    end
    chk(got, {tag, " completion seen"}, 64'(got), 64'h1);
    chk(ptr_p === 4'h0 && carry_out === 1'b0 && busy === 1'b0, "R7 flags at done",
        {59'd0, busy, ptr_p, carry_out}, 64'h0);
    chk(src_out === es && dst_out === et, {tag, " final pointers"},
        {4'd0, src_out, 20'd0, dst_out}, {4'd0, es, 20'd0, et});
    foreach (dut_m[k]) if (peek_dut(k) !== peek_ref(k)) errs++;
    foreach (ref_m[k]) if (peek_dut(k) !== peek_ref(k)) errs++;
    chk(errs == 0, {tag, " memory contents"}, 64'(errs), 64'h0);
    chk(rd_seen == int'(len) && wr_seen == int'(len), "R2 one read and one write per nibble",
        {32'(rd_seen), 32'(wr_seen)}, {32'(len), 32'(len)});
    chk(csum_seen == 0, "R6 checksum strobe", 64'(csum_seen), 64'h0);
    @(negedge clk);
    chk(done === 1'b0, "R7 done single cycle", 64'(done), 64'h0);
  endtask

  // {dir_up, src, dst, count}
  localparam logic [60:0] VEC [8] = '{
    {1'b0, 20'h01000, 20'h02000, 20'd37},  // R3 plain, non-multiple of 16
    {1'b1, 20'h03000, 20'h03005, 20'd40},  // R4 overlap toward higher addresses
    {1'b0, 20'h04010, 20'h04003, 20'd50},  // R3 overlap toward lower addresses
    {1'b0, 20'hFFFF8, 20'h00100, 20'd20},  // R5 source straddles the top
    {1'b1, 20'h00005, 20'h00200, 20'd23},  // R5 up mode wraps below zero
    {1'b1, 20'h06000, 20'h06008, 20'd16},  // R4 exactly one full chunk
    {1'b0, 20'h07000, 20'h07003, 20'd1},   // R3 single nibble
    {1'b0, 20'hFFFFE, 20'hFFFF0, 20'd33}   // R5 overlap plus wrap
  };

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && ptr_p === 4'h0 && carry_out === 1'b0 &&
        src_out === 20'h0 && mem_rd === 1'b0 && mem_wr === 1'b0,
        "R7 reset state", {58'd0, busy, done, ptr_p}, 64'h0);

    for (int v = 0; v < 8; v++) begin
      logic [60:0] e = VEC[v];
      logic d = e[60];
      logic [19:0] s = e[59:40], t = e[39:20], n = e[19:0];
      bit wraps = d ? ((s < n) || (t < n))
                    : ((21'(s) + 21'(n) > 21'h100000) || (21'(t) + 21'(n) > 21'h100000));
      string tag = wraps ? "R5" : (d ? "R4" : "R3");
      run_copy(d, s, t, n, 4'(v + 1), 1'b1, 1'b0, tag);
    end

    // R1 zero count
    run_copy(1'b0, 20'h0ABCD, 20'h0BCDE, 20'd0, 4'h9, 1'b1, 1'b0, "R1");
    // R8 start while busy must not disturb the running copy
    run_copy(1'b1, 20'h08000, 20'h08020, 20'd40, 4'hC, 1'b1, 1'b1, "R8");
    run_copy(1'b0, 20'h09000, 20'h09004, 20'd29, 4'h3, 1'b0, 1'b1, "R8");

    summary();
    $finish;
  end
endmodule